// File: doc/BRIEF.md
# Two-Level Inclusive Write-Through Data Cache

This block places two small on-chip caches between a single requester and a 16-bit word-addressed backing memory. A request carries a read or write flag, a word address and write data. One clock later the block returns the word, a code that names where the access was served (first level, second level or backing memory), and a flag that is set when the word has never been written.

Both levels are two-way set associative. The set is the block number modulo the set count, and one LRU bit per set picks the way to replace. The second level always holds every block that the first level holds. When a block is promoted or filled into the first level, it is also present in the second. When the second level evicts a block, any first-level copy of that block is dropped in the same cycle.

Writes go through to both levels and to the backing memory, so an eviction never needs a writeback. The backing memory is outside the block. The block reads one whole block from it combinationally, including per-word written flags, and issues single-word writes in the request cycle.

Top module: `tlc_cache`

## Requirements
- R1: A word address splits into a word offset (the low log2(WORDS) bits, 2 bits by default) and a block number (the remaining bits). The level-1 set is the block number modulo L1_SETS and the level-2 set is the block number modulo L2_SETS. During a request, `mem_blk_addr` equals the request's block number.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise. Requests may arrive on every cycle.
- R3: An access whose block is present in level 1 reports `rsp_level` = 2'd1, and a read returns the word from level 1.
- R4: A read or write whose block is absent from level 1 but present in level 2 reports `rsp_level` = 2'd2 and copies the whole block into level 1. A later access to that block reports 2'd1.
- R5: An access whose block is in neither level reports `rsp_level` = 2'd0 and installs the block from backing memory into both levels. A later access to that block reports 2'd1.
- R6: A write updates every level that holds the block or receives it, and it drives `mem_we` high with `mem_waddr`/`mem_wdata` equal to the request in that same cycle. Its response has `rsp_rdata` equal to the written data and `rsp_empty` low.
- R7: A read returns the most recently written value of the address, whichever level or memory serves it. Rewriting an address replaces the old value.
- R8: A read of a word that has never been written sets `rsp_empty` to 1. A read of a written word sets it to 0.
- R9: Inclusion: evicting a block from level 2 also removes it from level 1, so a later access to that block reports 2'd0 even if level 1 had it before.
- R10: The replacement way is the lowest-numbered invalid way of the set. If both ways are valid, it is the least recently used way. A level-1 read hit updates only level-1 recency. Every other access updates recency in both levels.
- R11: After reset both levels are empty and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_level | output | 2 | 0 = backing memory, 1 = level 1, 2 = level 2 |
| rsp_rdata | output | DATA_W | Read data (write data for writes) |
| rsp_empty | output | 1 | Word has never been written |
| mem_blk_addr | output | ADDR_W-log2(WORDS) | Block number read from backing memory |
| mem_blk_data | input | WORDS*DATA_W | Block contents, word 0 in the low bits |
| mem_blk_wr | input | WORDS | Per-word written flags of that block |
| mem_we | output | 1 | Backing memory write strobe |
| mem_waddr | output | ADDR_W | Backing memory write address |
| mem_wdata | output | DATA_W | Backing memory write data |

## Verification
The backing-memory outputs (`mem_blk_addr`, `mem_we`, `mem_waddr`, `mem_wdata`) are combinational from the request. The bench checks them one nanosecond after it drives the inputs, in the same half cycle, before the clock edge that accepts the request. All `rsp_*` outputs come from one register stage. The bench samples them on the falling edge after that accepting edge and then drives the next request at that same falling edge. A back-to-back stream therefore checks one response per cycle. Expected levels come from a tag-and-recency model in the bench. Expected data and empty flags come from a flat record of the last value written to each address.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

   typedef enum logic [1:0] {
      LVL_MEM = 2'd0,
      LVL_ONE = 2'd1,
      LVL_TWO = 2'd2
   } lvl_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tlc_blk_merge.sv
// Overlays one write word onto a block image and marks it written.
module tlc_blk_merge #(
   parameter int WORDS  = 4,
   parameter int DATA_W = 16,
   parameter int OFF_W  = $clog2(WORDS)
) (
   input  logic [WORDS*DATA_W-1:0] src_data,
   input  logic [WORDS-1:0]        src_wr,
   input  logic                    wr_en,
   input  logic [OFF_W-1:0]        wr_off,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [WORDS*DATA_W-1:0] dst_data,
   output logic [WORDS-1:0]        dst_wr
);

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic sel;
      assign sel = wr_en && (wr_off == OFF_W'(w));
      assign dst_data[w*DATA_W +: DATA_W] = sel ? wr_data : src_data[w*DATA_W +: DATA_W];
      assign dst_wr[w] = sel | src_wr[w];
   end

endmodule

// File: rtl/tlc_level.sv
// One two-way set-associative cache level with a single recency bit per set.
module tlc_level #(
   parameter int BLK_W  = 14,
   parameter int SETS   = 4,
   parameter int WAYS   = 2,
   parameter int WORDS  = 4,
   parameter int DATA_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [BLK_W-1:0]        lk_blk,
   output logic                    hit,
   output logic                    hit_way,
   output logic [WORDS*DATA_W-1:0] hit_data,
   output logic [WORDS-1:0]        hit_wr,
   output logic                    vic_way,
   output logic                    vic_valid,
   output logic [BLK_W-1:0]        vic_blk,
   input  logic                    touch_en,
   input  logic                    touch_way,
   input  logic                    upd_en,
   input  logic                    upd_way,
   input  logic [WORDS*DATA_W-1:0] upd_data,
   input  logic [WORDS-1:0]        upd_wr,
   input  logic                    inv_en,
   input  logic [BLK_W-1:0]        inv_blk
);

   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = BLK_W - SET_W;
   localparam int LINE_W = WORDS * DATA_W;

   if (WAYS != 2) begin : g_bad_ways
      $error("tlc_level: recency uses one bit per set, WAYS must be 2");
   end
   if (!tlc_pkg::is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("tlc_level: SETS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("tlc_level: block number too narrow for SETS");
   end

   logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
   logic              vld_q  [SETS][WAYS];
   logic [LINE_W-1:0] data_q [SETS][WAYS];
   logic [WORDS-1:0]  wr_q   [SETS][WAYS];
   logic              lru_q  [SETS];   // way to replace next

   logic [SET_W-1:0] lk_set, inv_set;
   logic [TAG_W-1:0] lk_tag, inv_tag;
   logic [WAYS-1:0]  way_hit, inv_hit;

   assign lk_set  = lk_blk[SET_W-1:0];
   assign lk_tag  = lk_blk[BLK_W-1:SET_W];
   assign inv_set = inv_blk[SET_W-1:0];
   assign inv_tag = inv_blk[BLK_W-1:SET_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign way_hit[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      assign inv_hit[w] = vld_q[inv_set][w] && (tag_q[inv_set][w] == inv_tag);
   end

   assign hit      = |way_hit;
   assign hit_way  = way_hit[1];
   assign hit_data = data_q[lk_set][hit_way];
   assign hit_wr   = wr_q[lk_set][hit_way];

   always_comb begin
      if (!vld_q[lk_set][0])      vic_way = 1'b0;
      else if (!vld_q[lk_set][1]) vic_way = 1'b1;
      else                        vic_way = lru_q[lk_set];
   end
   assign vic_valid = vld_q[lk_set][vic_way];
   assign vic_blk   = {tag_q[lk_set][vic_way], lk_set};

   // Valid and recency state: reset, invalidate, then install or touch.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            lru_q[s] <= 1'b0;
            for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
         end
      end else begin
         if (inv_en) begin
            for (int w = 0; w < WAYS; w++)
               if (inv_hit[w]) vld_q[inv_set][w] <= 1'b0;
         end
         if (upd_en) begin
            vld_q[lk_set][upd_way] <= 1'b1;
            lru_q[lk_set]          <= ~upd_way;
         end else if (touch_en) begin
            lru_q[lk_set] <= ~touch_way;
         end
      end
   end

   // Tag and payload arrays need no reset: they are qualified by vld_q.
   always_ff @(posedge clk) begin
      if (upd_en) begin
         tag_q[lk_set][upd_way]  <= lk_tag;
         data_q[lk_set][upd_way] <= upd_data;
         wr_q[lk_set][upd_way]   <= upd_wr;
      end
   end

   // R10: a block never occupies both ways of its set
   a_r10_unique_ways : assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_q[lk_set][0] && vld_q[lk_set][1] && (tag_q[lk_set][0] == tag_q[lk_set][1])));

   // R10: an install lands on a way that is invalid or on the recorded replacement way
   a_r10_install_way : assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !hit) |-> (!vld_q[lk_set][upd_way] ||
                            (vld_q[lk_set][0] && vld_q[lk_set][1] && upd_way == lru_q[lk_set])));

endmodule

// File: rtl/tlc_cache.sv
// Two-level inclusive write-through cache, one request per cycle, one-cycle response.
module tlc_cache import tlc_pkg::*; #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int WORDS   = 4,
   parameter int L1_SETS = 4,
   parameter int L2_SETS = 16,
   parameter int WAYS    = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req_valid,
   input  logic                                  req_we,
   input  logic [ADDR_W-1:0]                     req_addr,
   input  logic [DATA_W-1:0]                     req_wdata,
   output logic                                  rsp_valid,
   output logic [1:0]                            rsp_level,
   output logic [DATA_W-1:0]                     rsp_rdata,
   output logic                                  rsp_empty,
   output logic [ADDR_W-$clog2(WORDS)-1:0]       mem_blk_addr,
   input  logic [WORDS*DATA_W-1:0]               mem_blk_data,
   input  logic [WORDS-1:0]                      mem_blk_wr,
   output logic                                  mem_we,
   output logic [ADDR_W-1:0]                     mem_waddr,
   output logic [DATA_W-1:0]                     mem_wdata
);

   localparam int OFF_W  = $clog2(WORDS);
   localparam int BLK_W  = ADDR_W - OFF_W;
   localparam int LINE_W = WORDS * DATA_W;

   if (!is_pow2(WORDS) || WORDS < 2) begin : g_bad_words
      $error("tlc_cache: WORDS must be a power of two of at least 2");
   end
   if (BLK_W <= $clog2(L2_SETS) || BLK_W <= $clog2(L1_SETS)) begin : g_bad_addr
      $error("tlc_cache: address too narrow for the set counts");
   end

   logic [OFF_W-1:0] off;
   logic [BLK_W-1:0] blk;
   assign off = req_addr[OFF_W-1:0];
   assign blk = req_addr[ADDR_W-1:OFF_W];

   // Level lookup results
   logic              l1_hit, l1_hway, l1_vway, l1_vvalid;
   logic              l2_hit, l2_hway, l2_vway, l2_vvalid;
   logic [LINE_W-1:0] l1_hdata, l2_hdata;
   logic [WORDS-1:0]  l1_hwr, l2_hwr;
   logic [BLK_W-1:0]  l1_vblk, l2_vblk;

   // Block images
   logic [LINE_W-1:0] l2_src_data, l1_src_data, l2_new_data, l1_new_data;
   logic [WORDS-1:0]  l2_src_wr, l1_src_wr, l2_new_wr, l1_new_wr;

   // Level-2 image comes from level 2 on a hit, else from backing memory;
   // level-1 image comes from level 1 on a hit, else from the level-2 image.
   assign l2_src_data = l2_hit ? l2_hdata : mem_blk_data;
   assign l2_src_wr   = l2_hit ? l2_hwr   : mem_blk_wr;
   assign l1_src_data = l1_hit ? l1_hdata : l2_src_data;
   assign l1_src_wr   = l1_hit ? l1_hwr   : l2_src_wr;

   tlc_blk_merge #(.WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_merge_l2 (
      .src_data (l2_src_data),
      .src_wr   (l2_src_wr),
      .wr_en    (req_we),
      .wr_off   (off),
      .wr_data  (req_wdata),
      .dst_data (l2_new_data),
      .dst_wr   (l2_new_wr)
   );

   tlc_blk_merge #(.WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_merge_l1 (
      .src_data (l1_src_data),
      .src_wr   (l1_src_wr),
      .wr_en    (req_we),
      .wr_off   (off),
      .wr_data  (req_wdata),
      .dst_data (l1_new_data),
      .dst_wr   (l1_new_wr)
   );

   // Control: a level-1 read hit only refreshes level-1 recency; every other
   // access rewrites the block in both levels (data or recency).
   logic l1_touch, do_upd, l1_uway, l2_uway, inv_l1;
   assign l1_touch = req_valid && !req_we && l1_hit;
   assign do_upd   = req_valid && (req_we || !l1_hit);
   assign l1_uway  = l1_hit ? l1_hway : l1_vway;
   assign l2_uway  = l2_hit ? l2_hway : l2_vway;
   assign inv_l1   = do_upd && !l2_hit && l2_vvalid;

   tlc_level #(.BLK_W(BLK_W), .SETS(L1_SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W)) u_l1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_blk    (blk),
      .hit       (l1_hit),
      .hit_way   (l1_hway),
      .hit_data  (l1_hdata),
      .hit_wr    (l1_hwr),
      .vic_way   (l1_vway),
      .vic_valid (l1_vvalid),
      .vic_blk   (l1_vblk),
      .touch_en  (l1_touch),
      .touch_way (l1_hway),
      .upd_en    (do_upd),
      .upd_way   (l1_uway),
      .upd_data  (l1_new_data),
      .upd_wr    (l1_new_wr),
      .inv_en    (inv_l1),
      .inv_blk   (l2_vblk)
   );

   tlc_level #(.BLK_W(BLK_W), .SETS(L2_SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W)) u_l2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_blk    (blk),
      .hit       (l2_hit),
      .hit_way   (l2_hway),
      .hit_data  (l2_hdata),
      .hit_wr    (l2_hwr),
      .vic_way   (l2_vway),
      .vic_valid (l2_vvalid),
      .vic_blk   (l2_vblk),
      .touch_en  (1'b0),
      .touch_way (1'b0),
      .upd_en    (do_upd),
      .upd_way   (l2_uway),
      .upd_data  (l2_new_data),
      .upd_wr    (l2_new_wr),
      .inv_en    (1'b0),
      .inv_blk   ({BLK_W{1'b0}})
   );

   // Response
   lvl_e             lvl_d;
   logic [DATA_W-1:0] word_d;
   logic             empty_d;

   always_comb begin
      if (l1_hit)      lvl_d = LVL_ONE;
      else if (l2_hit) lvl_d = LVL_TWO;
      else             lvl_d = LVL_MEM;
      word_d  = req_we ? req_wdata : l1_src_data[int'(off)*DATA_W +: DATA_W];
      empty_d = !req_we && !l1_src_wr[off];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_level <= 2'd0;
         rsp_rdata <= '0;
         rsp_empty <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_level <= lvl_d;
            rsp_rdata <= word_d;
            rsp_empty <= empty_d;
         end
      end
   end

   // Backing memory port
   assign mem_blk_addr = blk;
   assign mem_we       = req_valid && req_we;
   assign mem_waddr    = req_addr;
   assign mem_wdata    = req_wdata;

   // R9: a level-1 hit always coincides with a level-2 hit
   a_r9_inclusion : assert property (@(posedge clk) disable iff (!rst_n)
      l1_hit |-> l2_hit);

   // R2: one response per request, exactly one cycle later
   a_r2_rsp_follows : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_rsp_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R3: a level-1 lookup hit is reported as level 1
   a_r3_l1_code : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && l1_hit) |=> (rsp_level == 2'd1));

   // R6: write responses never report an empty word
   a_r6_write_full : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_we) |=> !rsp_empty);

   // R9: an eviction that needs a level-1 purge never coincides with a level-1 hit
   a_r9_purge_miss : assert property (@(posedge clk) disable iff (!rst_n)
      inv_l1 |-> !l1_hit);

endmodule

// File: tb/tlc_cache_tb_top.sv
module tlc_cache_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_we;
   logic [15:0] req_addr, req_wdata;
   logic        rsp_valid, rsp_empty;
   logic [1:0]  rsp_level;
   logic [15:0] rsp_rdata;
   logic [13:0] mem_blk_addr;
   logic [63:0] mem_blk_data;
   logic [3:0]  mem_blk_wr;
   logic        mem_we;
   logic [15:0] mem_waddr, mem_wdata;

   always #2 clk = ~clk;   // 250 MHz

   tlc_cache dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_we       (req_we),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .rsp_valid    (rsp_valid),
      .rsp_level    (rsp_level),
      .rsp_rdata    (rsp_rdata),
      .rsp_empty    (rsp_empty),
      .mem_blk_addr (mem_blk_addr),
      .mem_blk_data (mem_blk_data),
      .mem_blk_wr   (mem_blk_wr),
      .mem_we       (mem_we),
      .mem_waddr    (mem_waddr),
      .mem_wdata    (mem_wdata)
   );

   // Backing memory: bench addresses stay in 0x0000-0x00FF and 0xFF00-0xFFFF
   logic [15:0] bmem [512];
   logic        bwr  [512];

   function automatic int midx(input logic [15:0] a);
      return int'({a[15], a[7:0]});
   endfunction

   always_comb begin
      for (int w = 0; w < 4; w++) begin
         mem_blk_data[w*16 +: 16] = bmem[midx({mem_blk_addr, 2'(w)})];
         mem_blk_wr[w]            = bwr[midx({mem_blk_addr, 2'(w)})];
      end
   end

   always @(posedge clk) begin
      if (mem_we) begin
         bmem[midx(mem_waddr)] <= mem_wdata;
         bwr[midx(mem_waddr)]  <= 1'b1;
      end
   end

   // Reference: last written value per address, plus tag/recency model
   logic [15:0] gold [512];
   bit          gwr  [512];
   int          m_tag [2][16][2];
   bit          m_vld [2][16][2];
   bit          m_lru [2][16];

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int m_sets(input int lv);
      return (lv == 0) ? 4 : 16;
   endfunction

   function automatic int m_find(input int lv, input int b);
      int s = b % m_sets(lv);
      for (int w = 0; w < 2; w++)
         if (m_vld[lv][s][w] && m_tag[lv][s][w] == b) return w;
      return -1;
   endfunction

   function automatic int m_vic(input int lv, input int b);
      int s = b % m_sets(lv);
      if (!m_vld[lv][s][0]) return 0;
      if (!m_vld[lv][s][1]) return 1;
      return int'(m_lru[lv][s]);
   endfunction

   task automatic m_put(input int lv, input int b, input int w);
      int s = b % m_sets(lv);
      m_tag[lv][s][w] = b;
      m_vld[lv][s][w] = 1'b1;
      m_lru[lv][s]    = (w == 0);
   endtask

   task automatic m_drop(input int lv, input int b);
      int s = b % m_sets(lv);
      for (int w = 0; w < 2; w++)
         if (m_vld[lv][s][w] && m_tag[lv][s][w] == b) m_vld[lv][s][w] = 1'b0;
   endtask

   // Called at a falling edge; returns at the next falling edge with checks done.
   task automatic access(input bit we, input logic [15:0] a, input logic [15:0] d, input string tag);
      int b = int'(a[15:2]);
      int h1 = m_find(0, b);
      int h2 = m_find(1, b);
      int lvl;
      logic [15:0] exp_d;
      bit exp_e;
      string lt;
      if (h1 >= 0) begin
         lvl = 1;
         if (we) begin m_put(0, b, h1); m_put(1, b, h2); end
         else m_lru[0][b % 4] = (h1 == 0);
      end else if (h2 >= 0) begin
         int v1 = m_vic(0, b);
         lvl = 2;
         m_put(1, b, h2);
         m_put(0, b, v1);
      end else begin
         int v1 = m_vic(0, b);
         int v2 = m_vic(1, b);
         lvl = 0;
         if (m_vld[1][b % 16][v2]) m_drop(0, m_tag[1][b % 16][v2]);
         m_put(1, b, v2);
         m_put(0, b, v1);
      end
      exp_d = we ? d : gold[midx(a)];
      exp_e = we ? 1'b0 : !gwr[midx(a)];
      lt = (lvl == 1) ? "R3" : (lvl == 2) ? "R4" : "R5";

      req_valid = 1'b1;
      req_we    = we;
      req_addr  = a;
      req_wdata = d;
      #1;
      chk(mem_blk_addr == a[15:2], "R1 block address", int'(mem_blk_addr), int'(a[15:2]));
      chk(mem_we == we, "R6 memory write strobe", int'(mem_we), int'(we));
      if (we) chk(mem_waddr == a && mem_wdata == d, "R6 memory write word",
                  int'({mem_waddr, mem_wdata}), int'({a, d}));
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R2 response valid", int'(rsp_valid), 1);
      chk(rsp_level == 2'(lvl), {tag, " ", lt, " level"}, int'(rsp_level), lvl);
      chk(rsp_empty == exp_e, "R8 empty flag", int'(rsp_empty), int'(exp_e));
      if (!exp_e) chk(rsp_rdata == exp_d, we ? "R6 write echo" : "R7 read data",
                      int'(rsp_rdata), int'(exp_d));
      if (we) begin
         gold[midx(a)] = d;
         gwr[midx(a)]  = 1'b1;
      end
   endtask

   task automatic idle();
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2 idle response", int'(rsp_valid), 0);
   endtask

   function automatic logic [15:0] rnd_addr();
      logic [31:0] r = $urandom;
      logic [7:0]  lo = r[8] ? {2'b00, r[14:9]} : r[22:15];
      return r[0] ? {8'hFF, lo} : {8'h00, lo};
   endfunction

   // Watchdog
   initial begin
      #400000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'h1357_2468));
      for (int i = 0; i < 512; i++) begin
         bmem[i] = 16'h0; bwr[i] = 1'b0; gold[i] = 16'h0; gwr[i] = 1'b0;
      end
      for (int lv = 0; lv < 2; lv++)
         for (int s = 0; s < 16; s++) begin
            m_lru[lv][s] = 1'b0;
            for (int w = 0; w < 2; w++) begin m_vld[lv][s][w] = 1'b0; m_tag[lv][s][w] = 0; end
         end
      rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R11 reset response", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11 idle after reset", int'(rsp_valid), 0);

      // R11/R5/R8: first read misses and is empty; R3: second read hits level 1
      access(1'b0, 16'h0010, 16'h0, "R11");
      access(1'b0, 16'h0010, 16'h0, "R5");
      // R6/R7: write then read back, then overwrite
      access(1'b1, 16'h0011, 16'hBEEF, "R6");
      access(1'b0, 16'h0011, 16'h0, "R7");
      access(1'b1, 16'h0011, 16'h1234, "R7");
      access(1'b0, 16'h0011, 16'h0, "R7");
      access(1'b0, 16'h0012, 16'h0, "R8");
      idle();

      // R10: recency picks the victim in a level-1 set shared by three blocks
      access(1'b1, 16'hFF00, 16'hA000, "R10");
      access(1'b1, 16'hFF40, 16'hA040, "R10");
      access(1'b0, 16'hFF00, 16'h0, "R10");
      access(1'b0, 16'hFF10, 16'h0, "R10");
      access(1'b0, 16'hFF00, 16'h0, "R10");
      access(1'b0, 16'hFF40, 16'h0, "R10");   // demoted to level 2, promoted back (R4)
      idle();

      // R9: level-2 eviction purges a block that level 1 still had
      access(1'b1, 16'h0080, 16'h0C80, "R9");
      access(1'b1, 16'h00C0, 16'h0CC0, "R9");
      access(1'b0, 16'h0080, 16'h0, "R9");    // level-1 hit, level-2 recency unchanged
      access(1'b0, 16'h0040, 16'h0, "R9");    // level-2 victim is block of 0x0080
      access(1'b0, 16'h0080, 16'h0, "R9");    // must come from memory again
      idle();

      // Random mix of reads and writes, back to back
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r = $urandom;
         access(r[1:0] == 2'b00, rnd_addr(), r[31:16], "RND");
         if (r[7:3] == 5'd0) idle();
      end
      idle();

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule